// File: doc/BRIEF.md
# Signed ALU with Registered Condition Flags

This block is the arithmetic and logic execution stage of a small fixed-point signal processor. Each issued operation takes two operands. Operand S has already been replaced by zero where the instruction asks for that. Operand T is either a register value or an immediate. The block forms a result that is `W` bits wide (24 by default) and a write-enable for the register bank. It also records eight condition flags that later instructions test. The result and the write-enable are combinational. The flags are held in a register that loads at the clock edge on which the operation issues.

The eight operations fall into two groups of four. The arithmetic group holds a conditional move, a conditional negated move, an add and a subtract. Both conditional moves write only when the currently selected condition flag is set. The logic group holds AND, OR, NOR and XOR. If the instruction names the reserved register as destination, the caller raises `destZero`. The operation then acts as a compare: the flags still load and nothing is written. The flags describe the mathematically exact value of the operation, not the wrapped result. A sum that overflows therefore still compares with the correct sign.

Top module: `dspAluFlags`

## Requirements
- R1: While `rstN` is low, and after its release until the first issued operation, `flags` reads 8'h59. The bit layout is bit0 eq, bit1 ne, bit2 ov, bit3 nv, bit4 ge, bit5 gt, bit6 le, bit7 lt.
- R2: For `opSel` 3'b010 the result is S+T modulo 2^W. For 3'b011 it is S−T modulo 2^W.
- R3: For `opSel` 3'b000 the result is T. For 3'b001 the result is −T modulo 2^W. S is ignored in both. `writeEn` is high for these two operations only if `condFlag` is 1.
- R4: For `opSel` 3'b100, 3'b101, 3'b110 and 3'b111 the result is the bitwise AND, OR, NOR and XOR of S and T.
- R5: When `destZero` is high, `writeEn` is low. The flags still load from that operation.
- R6: ov is set when the exact signed value of an add, subtract or negated move does not fit in W bits. A plain conditional move and every logic operation leave ov clear. nv is always the inverse of ov.
- R7: eq, gt and lt show whether the exact signed value is zero, positive or negative. ne, le and ge are the inverses of eq, gt and lt. For logic operations and moves the exact value is the result read as signed.
- R8: With `aluGo` low, `writeEn` is low and `flags` holds its value across the clock edge.
- R9: The flags of an operation issued with `aluGo` high appear on `flags` right after the next rising clock edge. The flags load whatever the value of `condFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| aluGo | input | 1 | An operation issues this cycle |
| opSel | input | 3 | Operation select; bit 2 picks the logic group |
| destZero | input | 1 | Destination is the reserved register (compare only) |
| condFlag | input | 1 | Selected condition flag for the conditional moves |
| opS | input | W | Operand S, zero-substituted by the caller |
| opT | input | W | Operand T or immediate |
| result | output | W | Combinational result |
| writeEn | output | 1 | Register-bank write strobe |
| flags | output | 8 | Registered flags {lt,le,gt,ge,nv,ov,ne,eq} |

## Verification
The assertions take for granted that `opSel`, `destZero` and `condFlag` are stable and known in every cycle in which `aluGo` is high. They also assume the caller has already placed zero on `opS` wherever the instruction calls for it, because the block never substitutes operands itself. The stimulus changes every input only on the falling clock edge, so all inputs are settled by the rising edge. It sweeps every pair of operand values for all eight operations at a narrow width, including the two extreme signed values, and it toggles the condition flag and the compare-only destination with patterns that are not tied to the operand values. Idle cycles with changing inputs are placed between issued operations so that the flag hold can be observed.

// File: rtl/dsp_alu_pkg.sv
package dsp_alu_pkg;

  typedef enum logic [2:0] {
    OP_CMOV = 3'b000,
    OP_CNEG = 3'b001,
    OP_ADD  = 3'b010,
    OP_SUB  = 3'b011,
    OP_AND  = 3'b100,
    OP_OR   = 3'b101,
    OP_NOR  = 3'b110,
    OP_XOR  = 3'b111
  } aluOp_e;

  typedef enum logic [1:0] {
    LF_AND = 2'b00,
    LF_OR  = 2'b01,
    LF_NOR = 2'b10,
    LF_XOR = 2'b11
  } logicFn_e;

  typedef struct packed {
    logic     selLogic;
    logicFn_e logicFn;
    logic     zeroS;
    logic     negT;
    logic     noOvf;
    logic     loadFlags;
  } aluStrobes_t;

  localparam int FLAG_N  = 8;
  localparam int FLG_EQ  = 0;
  localparam int FLG_NE  = 1;
  localparam int FLG_OV  = 2;
  localparam int FLG_NV  = 3;
  localparam int FLG_GE  = 4;
  localparam int FLG_GT  = 5;
  localparam int FLG_LE  = 6;
  localparam int FLG_LT  = 7;
  localparam logic [FLAG_N-1:0] FLAG_RESET = 8'h59;

endpackage

// File: rtl/dsp_alu_ctrl.sv
module dspAluCtrl
  import dsp_alu_pkg::*;
(
  input  logic        aluGo,
  input  logic [2:0]  opSel,
  input  logic        destZero,
  input  logic        condFlag,
  output aluStrobes_t strobes,
  output logic        writeEn
);

  aluOp_e op;
  logic   isCond;

  assign op     = aluOp_e'(opSel);
  assign isCond = (op == OP_CMOV) || (op == OP_CNEG);

  always_comb begin
    strobes           = '0;
    strobes.loadFlags = aluGo;
    strobes.selLogic  = opSel[2];
    strobes.logicFn   = logicFn_e'(opSel[1:0]);
    unique case (op)
      OP_CMOV: begin
        strobes.zeroS = 1'b1;
        strobes.noOvf = 1'b1;
      end
      OP_CNEG: begin
        strobes.zeroS = 1'b1;
        strobes.negT  = 1'b1;
      end
      OP_SUB:  strobes.negT  = 1'b1;
      OP_ADD:  strobes.negT  = 1'b0;
      default: strobes.noOvf = 1'b1;
    endcase
  end

  assign writeEn = aluGo && !destZero && (!isCond || condFlag);

endmodule

// File: rtl/dsp_alu_datapath.sv
module dspAluDatapath
  import dsp_alu_pkg::*;
#(
  parameter int W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobes_t       strobes,
  input  logic [W-1:0]      opS,
  input  logic [W-1:0]      opT,
  output logic [W-1:0]      result,
  output logic [FLAG_N-1:0] flags
);

  localparam int MSB = W - 1;

  logic [W-1:0] aVal;
  logic [W-1:0] bVal;
  logic [W-1:0] sumVal;
  logic [W-1:0] logicVal;
  logic         ovRaw;
  logic         ovNow;
  logic         isZero;
  logic         trueNeg;
  logic [FLAG_N-1:0] flagsNext;

  assign aVal   = strobes.zeroS ? '0 : opS;
  assign bVal   = strobes.negT ? ~opT : opT;
  assign sumVal = aVal + bVal + {{(W-1){1'b0}}, strobes.negT};
  assign ovRaw  = (aVal[MSB] == bVal[MSB]) && (sumVal[MSB] != aVal[MSB]);

  for (genvar b = 0; b < W; b++) begin : g_logicBit
    always_comb begin
      unique case (strobes.logicFn)
        LF_AND:  logicVal[b] = opS[b] & opT[b];
        LF_OR:   logicVal[b] = opS[b] | opT[b];
        LF_NOR:  logicVal[b] = ~(opS[b] | opT[b]);
        default: logicVal[b] = opS[b] ^ opT[b];
      endcase
    end
  end

  assign result  = strobes.selLogic ? logicVal : sumVal;
  assign ovNow   = !strobes.selLogic && !strobes.noOvf && ovRaw;
  assign isZero  = (result == '0) && !ovNow;
  assign trueNeg = result[MSB] ^ ovNow;

  always_comb begin
    flagsNext         = '0;
    flagsNext[FLG_EQ] = isZero;
    flagsNext[FLG_NE] = !isZero;
    flagsNext[FLG_OV] = ovNow;
    flagsNext[FLG_NV] = !ovNow;
    flagsNext[FLG_LT] = trueNeg;
    flagsNext[FLG_GE] = !trueNeg;
    flagsNext[FLG_GT] = !trueNeg && !isZero;
    flagsNext[FLG_LE] = trueNeg || isZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= FLAG_RESET;
    else if (strobes.loadFlags) flags <= flagsNext;
  end

endmodule

// File: rtl/dspAluFlags.sv
module dspAluFlags
  import dsp_alu_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         aluGo,
  input  logic [2:0]   opSel,
  input  logic         destZero,
  input  logic         condFlag,
  input  logic [W-1:0] opS,
  input  logic [W-1:0] opT,
  output logic [W-1:0] result,
  output logic         writeEn,
  output logic [7:0]   flags
);

  aluStrobes_t strobes;

  dspAluCtrl u_ctrl (
    .aluGo    (aluGo),
    .opSel    (opSel),
    .destZero (destZero),
    .condFlag (condFlag),
    .strobes  (strobes),
    .writeEn  (writeEn)
  );

  dspAluDatapath #(.W(W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opS     (opS),
    .opT     (opT),
    .result  (result),
    .flags   (flags)
  );

endmodule

// File: rtl/dspAluFlags_chk.sv
module dspAluFlags_chk (
  input logic       clk,
  input logic       rstN,
  input logic       aluGo,
  input logic [2:0] opSel,
  input logic       destZero,
  input logic       condFlag,
  input logic       writeEn,
  input logic [7:0] flags
);

  // R5: a compare never writes
  a_r5_no_write_on_compare: assert property (@(posedge clk) disable iff (!rstN)
    destZero |-> !writeEn);

  // R3: conditional moves with a clear flag do not write
  a_r3_cond_gate: assert property (@(posedge clk) disable iff (!rstN)
    (aluGo && opSel[2:1] == 2'b00 && !condFlag) |-> !writeEn);

  // R8: idle cycles hold the flags and do not write
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !aluGo |=> $stable(flags));
  a_r8_no_write_idle: assert property (@(posedge clk) disable iff (!rstN)
    !aluGo |-> !writeEn);

  // R6: logic operations clear ov
  a_r6_logic_clears_ov: assert property (@(posedge clk) disable iff (!rstN)
    (aluGo && opSel[2]) |=> (!flags[2] && flags[3]));

  // R7: complementary flags stay complementary
  a_r7_flag_pairs: assert property (@(posedge clk) disable iff (!rstN)
    (flags[0] ^ flags[1]) && (flags[4] ^ flags[7]) && (flags[5] ^ flags[6]));
  a_r7_gt_implies_ge: assert property (@(posedge clk) disable iff (!rstN)
    flags[5] |-> (flags[4] && !flags[0]));

endmodule

bind dspAluFlags dspAluFlags_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .aluGo    (aluGo),
  .opSel    (opSel),
  .destZero (destZero),
  .condFlag (condFlag),
  .writeEn  (writeEn),
  .flags    (flags)
);

// File: tb/sim_dspAluFlags.sv
`timescale 1ns/1ps
module sim_dspAluFlags;

  localparam int W    = 5;
  localparam int SPAN = 1 << W;
  localparam int HALF = 1 << (W - 1);

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         aluGo = 1'b0;
  logic [2:0]   opSel = '0;
  logic         destZero = 1'b0;
  logic         condFlag = 1'b0;
  logic [W-1:0] opS = '0;
  logic [W-1:0] opT = '0;
  logic [W-1:0] result;
  logic         writeEn;
  logic [7:0]   flags;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] expFlags = 8'h59;

  always #2 clk = ~clk;

  dspAluFlags #(.W(W)) u0 (
    .clk(clk), .rstN(rstN), .aluGo(aluGo), .opSel(opSel), .destZero(destZero),
    .condFlag(condFlag), .opS(opS), .opT(opT), .result(result),
    .writeEn(writeEn), .flags(flags)
  );

  function automatic int sgn(input int v);
    return (v >= HALF) ? v - SPAN : v;
  endfunction

  function automatic string reqOf(input int op);
    if (op <= 1) return "R3";
    if (op <= 3) return "R2";
    return "R4";
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // one issued operation: drive at negedge, check comb outputs, flags checked next cycle
  task automatic issue(input int op, input int s, input int t, input bit cf, input bit dz);
    int exact;
    int res;
    bit ov;
    bit weE;
    @(negedge clk);
    check("R9 flags", flags, expFlags);
    aluGo = 1'b1; opSel = 3'(op); opS = W'(s); opT = W'(t);
    condFlag = cf; destZero = dz;
    ov = 0;
    case (op)
      0: exact = sgn(t);
      1: exact = -sgn(t);
      2: exact = sgn(s) + sgn(t);
      3: exact = sgn(s) - sgn(t);
      4: exact = sgn(s & t);
      5: exact = sgn(s | t);
      6: exact = sgn(~(s | t) & (SPAN - 1));
      default: exact = sgn(s ^ t);
    endcase
    if (op >= 1 && op <= 3) ov = (exact < -HALF) || (exact > HALF - 1);
    res = exact & (SPAN - 1);
    weE = !dz && ((op >= 2) || cf);
    #1;
    check(reqOf(op), result, res);
    check(dz ? "R5" : "R3 writeEn", writeEn, weE);
    // R6 R7 expected flag vector
    expFlags = {exact < 0, exact <= 0, exact > 0, exact >= 0, !ov, ov, exact != 0, exact == 0};
  endtask

  task automatic idle(input int s, input int t);
    @(negedge clk);
    check("R9 flags", flags, expFlags);
    aluGo = 1'b0; opSel = 3'(s); opS = W'(s); opT = W'(t); condFlag = 1'b1; destZero = 1'b0;
    #1;
    check("R8 writeEn idle", writeEn, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset flags", flags, 8'h59);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 flags after release", flags, 8'h59);
    for (int op = 0; op < 8; op++) begin
      for (int s = 0; s < SPAN; s++) begin
        for (int t = 0; t < SPAN; t++) begin
          issue(op, s, t, ((s * 3 + t) % 5) < 2, ((s + 2 * t + op) % 7) == 0);
          if (((s + t) % 11) == 0) idle(s ^ 5, t ^ 9);
        end
      end
    end
    // explicit corners: extreme values
    issue(1, 0, HALF, 1, 0);        // R6 negate most negative overflows
    issue(2, HALF, HALF, 1, 1);     // R6 R7 wrap to zero is not eq; compare only
    issue(3, HALF - 1, HALF, 0, 0); // R6 positive overflow, gt
    issue(0, 7, HALF, 0, 0);        // R3 move with flag clear: no write, flags load
    idle(1, 2);
    idle(3, 4);
    @(negedge clk);
    check("R9 flags final", flags, expFlags);
    done = 1;
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R9 watchdog actual=running expected=done");
      finishRun();
    end
  end

endmodule